// File: doc/BRIEF.md
# Extended State Enable Register Controller

This block owns the architectural component-enable register that tells the core which pieces of extended register state the operating system manages, and it turns that register together with three control-register bits into the enables that gate vector and SIMD execution. Software writes the register with a 64-bit value split into a high and a low 32-bit half, and reads it back through a registered read port. Every access is validated. An illegal access raises a general-protection fault with error code zero, and the register is left untouched.

The register has three implemented component bits. Bit 0 is x87 state, bit 1 is SSE state (the 128-bit registers and the SIMD control/status word), and bit 2 is the upper halves of the wide vector registers. The control bits come from an external register file as plain inputs. They are the OS extended-save enable (control bit 18), the SIMD floating-point exception enable (control bit 10) and the legacy 128-bit SIMD enable (control bit 9).

Both request strobes are single-cycle valid pulses with no ready signal. The block accepts a request in the cycle it is presented and never applies back-pressure. A read result appears with a one-cycle done pulse in the cycle after the read strobe. A fault appears as a one-cycle pulse in the cycle after the rejected strobe.

Top module: `xse_ctrl_top`

## Requirements
- R1: After reset the register holds 64'h1 (x87 only), and `gp_fault` and `rd_done` are 0.
- R2: When `ctl_save_en` (control bit 18) is 0, a write or a read pulses `gp_fault` one cycle later. The register is unchanged and `rd_done` stays 0.
- R3: A write whose bits [2:1] are 2'b10 (wide set, SSE clear) faults, and the register keeps its previous value.
- R4: A legal write with `ctl_save_en` = 1, such as high=0x0 and low=0x7, is accepted without a fault. The new value is readable from the next cycle.
- R5: A write with bit 0 clear faults, because x87 state can never be disabled.
- R6: A write with any bit set above bit 2, in either the low or the high half, faults.
- R7: A read accepted with `ctl_save_en` = 1 drives `rd_done` high for exactly the next cycle. In that cycle `rd_hi`/`rd_lo` carry the register value as it stood at the read strobe.
- R8: `gp_fault` is a one-cycle pulse that follows only a rejected access. An accepted access never raises it.
- R9: `wide_vec_on` is 1 exactly when `ctl_save_en` = 1 and register bits [2:1] are both 1.
- R10: `simd_exc_on` follows `ctl_fp_exc_en` (control bit 10).
- R11: `legacy_simd_on` follows `ctl_legacy_simd_en` (control bit 9). That bit has no effect on `wide_vec_on`.
- R12: When both strobes are high in one cycle, only the write is performed. The read produces neither `rd_done` nor a fault of its own.
- R13: `x87_mgd` is 1 exactly when `ctl_save_en` = 1 and register bit 0 is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_save_en | input | 1 | Control bit 18: OS extended-save enable |
| ctl_fp_exc_en | input | 1 | Control bit 10: SIMD floating-point exception enable |
| ctl_legacy_simd_en | input | 1 | Control bit 9: legacy 128-bit SIMD enable |
| wr_valid | input | 1 | Single-cycle write strobe |
| wr_hi | input | 32 | Write value bits [63:32] |
| wr_lo | input | 32 | Write value bits [31:0] |
| rd_valid | input | 1 | Single-cycle read strobe |
| rd_done | output | 1 | Read data valid, one cycle after an accepted read |
| rd_hi | output | 32 | Read value bits [63:32] |
| rd_lo | output | 32 | Read value bits [31:0] |
| gp_fault | output | 1 | General-protection fault pulse, error code zero |
| x87_mgd | output | 1 | x87 state managed |
| wide_vec_on | output | 1 | Wide-vector and fused multiply-add instructions usable |
| legacy_simd_on | output | 1 | Legacy 128-bit SIMD instructions usable |
| simd_exc_on | output | 1 | SIMD floating-point exceptions enabled |

## Verification
The bench aims at the rejection rules: bits [2:1] set to 2'b10, bit 0 cleared, bits set only in the high half, and the all-components value 0x7. A design with a wrong legality check would either take an illegal value, which later shows up on a read or on `wide_vec_on`, or fault on the legal one. Accesses made while the save-enable bit is low check that the gate covers reads as well as writes. Cycles with both strobes high catch a design that lets the read through. Toggling control bit 9 against the wide-vector enable catches a decoder that mixes up the legacy and wide paths.

// File: rtl/xse_pkg.sv
package xse_pkg;
  localparam int REG_W      = 64;
  localparam int HALF_W     = 32;
  localparam int NUM_COMP   = 3;
  localparam int COMP_X87   = 0;
  localparam int COMP_SSE   = 1;
  localparam int COMP_WIDE  = 2;
  localparam logic [REG_W-1:0] RESET_MASK = 64'h1;

  typedef enum logic [2:0] {
    REJ_NONE,
    REJ_DISABLED,
    REJ_UNSUPPORTED,
    REJ_NO_BASE,
    REJ_WIDE_NO_SSE
  } rej_e;
endpackage

// File: rtl/xse_wr_check.sv
module xse_wr_check
  import xse_pkg::*;
#(
  parameter int NCOMP = NUM_COMP
) (
  input  logic             save_en,
  input  logic [REG_W-1:0] value,
  output rej_e             cause
);
  localparam logic [REG_W-1:0] SUP_MASK = (REG_W'(1) << NCOMP) - REG_W'(1);

  logic unsupported;
  assign unsupported = |(value & ~SUP_MASK);

  always_comb begin
    if (!save_en)
      cause = REJ_DISABLED;
    else if (unsupported)
      cause = REJ_UNSUPPORTED;
    else if (!value[COMP_X87])
      cause = REJ_NO_BASE;
    else if (value[COMP_WIDE] && !value[COMP_SSE])
      cause = REJ_WIDE_NO_SSE;
    else
      cause = REJ_NONE;
  end
endmodule

// File: rtl/xse_mask_reg.sv
module xse_mask_reg
  import xse_pkg::*;
#(
  parameter int NCOMP = NUM_COMP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             save_en,
  input  logic             wr_valid,
  input  logic [REG_W-1:0] wr_value,
  input  rej_e             wr_cause,
  input  logic             rd_valid,
  output logic [REG_W-1:0] mask,
  output logic [REG_W-1:0] rd_data,
  output logic             rd_done,
  output logic             fault
);
  logic rd_take, wr_ok, wr_bad, rd_ok, rd_bad;

  assign rd_take = rd_valid && !wr_valid;
  assign wr_ok   = wr_valid && (wr_cause == REJ_NONE);
  assign wr_bad  = wr_valid && (wr_cause != REJ_NONE);
  assign rd_ok   = rd_take && save_en;
  assign rd_bad  = rd_take && !save_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask    <= RESET_MASK;
      rd_data <= '0;
      rd_done <= 1'b0;
      fault   <= 1'b0;
    end else begin
      fault   <= wr_bad || rd_bad;
      rd_done <= rd_ok;
      if (rd_ok) rd_data <= mask;
      if (wr_ok) mask    <= wr_value;
    end
  end

  // R5
  x87_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask[COMP_X87]);
  // R3
  wide_needs_sse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask[COMP_WIDE] |-> mask[COMP_SSE]);
  // R6
  no_unsup_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask >> NCOMP) == '0);
  // R2
  gated_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_valid || rd_valid) && !save_en) |=> (fault && !rd_done));
  // R7
  read_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !wr_valid && save_en) |=> (rd_done && !fault));
  // R12
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && rd_valid) |=> !rd_done);
  // R4
  mask_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mask) |-> ($past(wr_valid) && !fault));
  // R8
  fault_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault && rd_done));
endmodule

// File: rtl/xse_enable_decode.sv
module xse_enable_decode
  import xse_pkg::*;
#(
  parameter int NCOMP = NUM_COMP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             save_en,
  input  logic             fp_exc_en,
  input  logic             legacy_en,
  input  logic [REG_W-1:0] mask,
  output logic [NCOMP-1:0] comp_mgd,
  output logic             wide_on,
  output logic             legacy_on,
  output logic             exc_on
);
  for (genvar g = 0; g < NCOMP; g++) begin : g_comp
    assign comp_mgd[g] = save_en && mask[g];
  end

  assign wide_on   = comp_mgd[COMP_WIDE] && comp_mgd[COMP_SSE];
  assign legacy_on = legacy_en;
  assign exc_on    = fp_exc_en;

  // R9
  wide_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wide_on |-> (save_en && mask[COMP_SSE] && mask[COMP_WIDE]));
  // R13
  x87_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    comp_mgd[COMP_X87] |-> save_en);
endmodule

// File: rtl/xse_ctrl_top.sv
module xse_ctrl_top
  import xse_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_save_en,
  input  logic              ctl_fp_exc_en,
  input  logic              ctl_legacy_simd_en,
  input  logic              wr_valid,
  input  logic [HALF_W-1:0] wr_hi,
  input  logic [HALF_W-1:0] wr_lo,
  input  logic              rd_valid,
  output logic              rd_done,
  output logic [HALF_W-1:0] rd_hi,
  output logic [HALF_W-1:0] rd_lo,
  output logic              gp_fault,
  output logic              x87_mgd,
  output logic              wide_vec_on,
  output logic              legacy_simd_on,
  output logic              simd_exc_on
);
  logic [REG_W-1:0]    wr_value, mask, rd_data;
  logic [NUM_COMP-1:0] comp_mgd;
  rej_e                cause;

  assign wr_value = {wr_hi, wr_lo};

  xse_wr_check #(.NCOMP(NUM_COMP)) u_check (
    .save_en (ctl_save_en),
    .value   (wr_value),
    .cause   (cause)
  );

  xse_mask_reg #(.NCOMP(NUM_COMP)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .save_en  (ctl_save_en),
    .wr_valid (wr_valid),
    .wr_value (wr_value),
    .wr_cause (cause),
    .rd_valid (rd_valid),
    .mask     (mask),
    .rd_data  (rd_data),
    .rd_done  (rd_done),
    .fault    (gp_fault)
  );

  xse_enable_decode #(.NCOMP(NUM_COMP)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .save_en   (ctl_save_en),
    .fp_exc_en (ctl_fp_exc_en),
    .legacy_en (ctl_legacy_simd_en),
    .mask      (mask),
    .comp_mgd  (comp_mgd),
    .wide_on   (wide_vec_on),
    .legacy_on (legacy_simd_on),
    .exc_on    (simd_exc_on)
  );

  assign x87_mgd = comp_mgd[COMP_X87];
  assign rd_hi   = rd_data[REG_W-1:HALF_W];
  assign rd_lo   = rd_data[HALF_W-1:0];
endmodule

// File: tb/tb_xse_ctrl_top.sv
`timescale 1ns/1ps
module tb_xse_ctrl_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_save_en = 1'b0, ctl_fp_exc_en = 1'b0, ctl_legacy_simd_en = 1'b0;
  logic wr_valid = 1'b0, rd_valid = 1'b0;
  logic [31:0] wr_hi = '0, wr_lo = '0;
  logic rd_done, gp_fault, x87_mgd, wide_vec_on, legacy_simd_on, simd_exc_on;
  logic [31:0] rd_hi, rd_lo;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [63:0] model = 64'h1;

  always #4 clk = ~clk;

  xse_ctrl_top dut (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string rej_tag(bit se, logic [31:0] hi, logic [31:0] lo);
    if (!se) return "R2";
    if (hi != 0 || lo[31:3] != 0) return "R6";
    if (!lo[0]) return "R5";
    if (lo[2:1] == 2'b10) return "R3";
    return "";
  endfunction

  task automatic check_enables();
    chk("R13 x87_mgd", 64'(x87_mgd), 64'(ctl_save_en & model[0]));
    chk("R9 wide_vec_on", 64'(wide_vec_on), 64'(ctl_save_en & model[1] & model[2]));
    chk("R11 legacy_simd_on", 64'(legacy_simd_on), 64'(ctl_legacy_simd_en));
    chk("R10 simd_exc_on", 64'(simd_exc_on), 64'(ctl_fp_exc_en));
  endtask

  // Drive one cycle of stimulus at negedge, check results at the following negedge.
  task automatic step(bit w, bit r, logic [31:0] hi, logic [31:0] lo,
                      bit se, bit fe, bit le);
    string t;
    bit exp_fault, exp_done;
    logic [63:0] exp_rd;
    ctl_save_en = se; ctl_fp_exc_en = fe; ctl_legacy_simd_en = le;
    wr_valid = w; rd_valid = r; wr_hi = hi; wr_lo = lo;
    t = rej_tag(se, hi, lo);
    exp_fault = 0; exp_done = 0; exp_rd = model;
    if (w) begin
      if (t != "") exp_fault = 1;
      else model = {hi, lo};
    end else if (r) begin
      if (!se) exp_fault = 1;
      else exp_done = 1;
    end
    @(posedge clk);
    @(negedge clk);
    wr_valid = 0; rd_valid = 0;
    if (w && r) chk("R12 rd_done suppressed", 64'(rd_done), 64'(0));
    else if (exp_done) chk("R7 rd_done", 64'(rd_done), 64'(1));
    else chk("R2 rd_done low", 64'(rd_done), 64'(0));
    if (exp_done) chk("R7 rd data", {rd_hi, rd_lo}, exp_rd);
    if (exp_fault) chk({t == "" ? "R2" : t, " fault"}, 64'(gp_fault), 64'(1));
    else chk((w ? "R4 no fault" : "R8 no fault"), 64'(gp_fault), 64'(0));
    check_enables();
    if (exp_fault) begin
      @(negedge clk);
      chk("R8 fault one cycle", 64'(gp_fault), 64'(0));
    end
  endtask

  task automatic rd_back(string tag);
    step(0, 1, 0, 0, 1, ctl_fp_exc_en, ctl_legacy_simd_en);
    chk(tag, {rd_hi, rd_lo}, model);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1977));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 gp_fault reset", 64'(gp_fault), 64'(0));
    chk("R1 rd_done reset", 64'(rd_done), 64'(0));
    rd_back("R1 reset value");

    step(1, 0, 0, 7, 0, 0, 0);             // R2 write gated off
    step(0, 1, 0, 0, 0, 0, 0);             // R2 read gated off
    rd_back("R2 value unchanged");
    step(1, 0, 0, 7, 1, 0, 0);             // R4 all components
    rd_back("R4 value 7 accepted");
    step(1, 0, 0, 5, 1, 0, 0);             // R3 wide without SSE
    rd_back("R3 value kept");
    step(1, 0, 0, 6, 1, 0, 0);             // R5 bit 0 clear
    step(1, 0, 0, 32'hF, 1, 0, 0);         // R6 low-half extra bit
    step(1, 0, 1, 7, 1, 0, 0);             // R6 high-half bit
    rd_back("R6 value kept");
    step(1, 1, 0, 3, 1, 0, 0);             // R12 write wins
    rd_back("R12 write applied");
    step(1, 1, 0, 5, 1, 0, 0);             // R12 illegal write, read still ignored
    step(1, 0, 0, 7, 1, 0, 0);
    step(0, 0, 0, 0, 1, 0, 1);             // R11 legacy on, wide on
    step(0, 0, 0, 0, 1, 1, 0);             // R10, R11 legacy off does not touch wide
    step(0, 0, 0, 0, 0, 1, 1);             // R9, R13 save bit low
    step(1, 0, 0, 1, 1, 0, 1);             // R9 wide off with x87 only
    rd_back("R4 x87 only");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] hi, lo;
      bit w, r;
      int k;
      k  = int'($urandom_range(0, 9));
      hi = (k == 0) ? $urandom() : 32'h0;
      lo = (k == 1) ? $urandom() : 32'($urandom_range(0, 7));
      w  = ($urandom_range(0, 2) != 0);
      r  = ($urandom_range(0, 2) == 0);
      step(w, r, hi, lo, ($urandom_range(0, 4) != 0),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule